// File: doc/BRIEF.md
# Rotating Complex Integer Dot-Product Accumulator

This block treats two wide source vectors as packed signed complex numbers. It adds a complex dot product into each lane of a third vector, the accumulator, and returns the updated vector. The format input picks one of two packings. In the narrow packing, bytes accumulate into 32-bit lanes. In the wide packing, 16-bit halfwords accumulate into 64-bit lanes. Within a source vector, each complex value is an adjacent pair of elements. The lower-indexed (even) element holds the real part and the odd element holds the imaginary part. Each destination lane covers four source elements, which is two complex values, and it sums both of their products.

A two-bit rotation code turns the second operand by 0, 90, 180 or 270 degrees before multiplying. With it, one lane can produce any of four results: the real or the imaginary part of a plain dot product, or the real or the imaginary part of a conjugate dot product. The datapath is a fixed two-stage pipeline. A beat is offered with `in_valid` and its result appears with `out_valid` exactly two clocks later. The block has no ready signal and never back-pressures, so it takes a new beat every clock. Whatever consumes `out_data` must take each result in the cycle it is flagged.

Top module: `cdot_accum`

## Requirements
- R1: With `in_size`=0, the vectors hold signed 8-bit elements (element k at bits 8k+7..8k) and results go to VLEN/32 lanes of 32 bits, lane e at bits 32e+31..32e.
- R2: With `in_size`=1, the vectors hold signed 16-bit elements (element k at bits 16k+15..16k) and results go to VLEN/64 lanes of 64 bits.
- R3: Lane e uses elements 4e..4e+3 of each source as two complex values: real parts at 4e and 4e+2, imaginary parts at 4e+1 and 4e+3. The lane result is the accumulator lane plus the contributions of both complex values.
- R4: `in_rot`=00 adds x.re*y.re − x.im*y.im for each complex pair.
- R5: `in_rot`=01 adds x.re*y.im + x.im*y.re for each complex pair.
- R6: `in_rot`=10 adds x.re*y.re + x.im*y.im for each complex pair.
- R7: `in_rot`=11 adds x.re*y.im − x.im*y.re for each complex pair.
- R8: Products and sums are exact and then reduced modulo 2^32 or 2^64. There is no saturation, and the most negative inputs are handled (−128·−128, −32768·−32768).
- R9: `out_valid` is high exactly two cycles after each cycle in which `in_valid` is high, and low otherwise. A beat is accepted in every cycle, with no stall.
- R10: A synchronous active-high `rst` forces `out_valid` low on the following edge and drops any beats in flight.
- R11: When the first source is all zero, `out_data` equals the accumulator input of that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on the inputs |
| in_size | input | 1 | 0: 8-bit into 32-bit lanes; 1: 16-bit into 64-bit lanes |
| in_rot | input | 2 | Rotation code of the second source |
| in_src1 | input | VLEN | First source vector of complex values |
| in_src2 | input | VLEN | Second source vector, rotated |
| in_acc | input | VLEN | Accumulator vector |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | VLEN | Updated accumulator vector |

## Verification
Two things can land in the same cycle: a new beat entering the multiply stage, and an older beat being summed in the accumulate stage with a different format or rotation. The bench provokes this with random streams of back-to-back beats. Each beat picks its size and rotation independently, so neighbouring beats in the pipe differ, and every result is compared lane by lane against a per-rotation complex formula. The same collision happens between reset and beats in flight. It is judged by asserting reset while beats are in the pipe and then requiring `out_valid` to stay low until fresh beats arrive.

// File: rtl/cdot_pkg.sv
package cdot_pkg;
  typedef enum logic [1:0] {
    ROT_0   = 2'b00,
    ROT_90  = 2'b01,
    ROT_180 = 2'b10,
    ROT_270 = 2'b11
  } rot_e;

  typedef struct packed {
    logic swap;   // second-source operand a is the odd (imaginary) element
    logic sub;    // second product term is subtracted
  } rot_ctl_t;
endpackage

// File: rtl/cdot_rot_decode.sv
module cdot_rot_decode
  import cdot_pkg::*;
(
  input  logic [1:0] rot,
  output rot_ctl_t   ctl
);
  always_comb begin
    unique case (rot_e'(rot))
      ROT_0:   ctl = '{swap: 1'b0, sub: 1'b1};
      ROT_90:  ctl = '{swap: 1'b1, sub: 1'b0};
      ROT_180: ctl = '{swap: 1'b0, sub: 1'b0};
      default: ctl = '{swap: 1'b1, sub: 1'b1};
    endcase
  end
endmodule

// File: rtl/cdot_lane.sv
module cdot_lane #(
  parameter int EW = 8
) (
  input  logic            clk,
  input  logic            swap,
  input  logic            sub,
  input  logic [4*EW-1:0] src1,
  input  logic [4*EW-1:0] src2,
  input  logic [4*EW-1:0] acc,
  output logic [4*EW-1:0] res
);
  localparam int LW = 4 * EW;
  localparam int PW = 2 * EW;

  logic signed [PW-1:0] pa_q [2];
  logic signed [PW-1:0] pb_q [2];
  logic [LW-1:0]        acc_q;
  logic                 sub_q;
  logic [LW-1:0]        res_q;

  // stage 1: operand pick and the four narrow multiplies
  for (genvar i = 0; i < 2; i++) begin : g_pair
    logic signed [EW-1:0] x_re, x_im, y_a, y_b;
    assign x_re = src1[(2*i)*EW +: EW];
    assign x_im = src1[(2*i+1)*EW +: EW];
    assign y_a  = swap ? src2[(2*i+1)*EW +: EW] : src2[(2*i)*EW +: EW];
    assign y_b  = swap ? src2[(2*i)*EW +: EW]   : src2[(2*i+1)*EW +: EW];

    always_ff @(posedge clk) begin
      pa_q[i] <= x_re * y_a;
      pb_q[i] <= x_im * y_b;
    end
  end

  always_ff @(posedge clk) begin
    acc_q <= acc;
    sub_q <= sub;
  end

  // stage 2: sign-extend, combine, accumulate with wrap
  logic [LW-1:0] ea0, ea1, eb0, eb1, bsum, total;
  always_comb begin
    ea0   = {{(LW-PW){pa_q[0][PW-1]}}, pa_q[0]};
    ea1   = {{(LW-PW){pa_q[1][PW-1]}}, pa_q[1]};
    eb0   = {{(LW-PW){pb_q[0][PW-1]}}, pb_q[0]};
    eb1   = {{(LW-PW){pb_q[1][PW-1]}}, pb_q[1]};
    bsum  = eb0 + eb1;
    total = sub_q ? (acc_q + ea0 + ea1 - bsum) : (acc_q + ea0 + ea1 + bsum);
  end

  always_ff @(posedge clk) res_q <= total;

  assign res = res_q;
endmodule

// File: rtl/cdot_accum.sv
module cdot_accum
  import cdot_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_size,
  input  logic [1:0]      in_rot,
  input  logic [VLEN-1:0] in_src1,
  input  logic [VLEN-1:0] in_src2,
  input  logic [VLEN-1:0] in_acc,
  output logic            out_valid,
  output logic [VLEN-1:0] out_data
);
  localparam int NARROW_LW = 32;
  localparam int WIDE_LW   = 64;
  localparam int N_NARROW  = VLEN / NARROW_LW;
  localparam int N_WIDE    = VLEN / WIDE_LW;

  rot_ctl_t ctl;
  cdot_rot_decode u_dec (.rot(in_rot), .ctl(ctl));

  logic [VLEN-1:0] res_narrow, res_wide;

  for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
    cdot_lane #(.EW(NARROW_LW/4)) u_lane (
      .clk (clk),
      .swap(ctl.swap),
      .sub (ctl.sub),
      .src1(in_src1[k*NARROW_LW +: NARROW_LW]),
      .src2(in_src2[k*NARROW_LW +: NARROW_LW]),
      .acc (in_acc[k*NARROW_LW +: NARROW_LW]),
      .res (res_narrow[k*NARROW_LW +: NARROW_LW])
    );
  end

  for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
    cdot_lane #(.EW(WIDE_LW/4)) u_lane (
      .clk (clk),
      .swap(ctl.swap),
      .sub (ctl.sub),
      .src1(in_src1[k*WIDE_LW +: WIDE_LW]),
      .src2(in_src2[k*WIDE_LW +: WIDE_LW]),
      .acc (in_acc[k*WIDE_LW +: WIDE_LW]),
      .res (res_wide[k*WIDE_LW +: WIDE_LW])
    );
  end

  logic v1_q, v2_q;
  logic sz1_q, sz2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    sz1_q <= in_size;
    sz2_q <= sz1_q;
  end

  assign out_valid = v2_q;
  assign out_data  = sz2_q ? res_wide : res_narrow;
endmodule

// File: rtl/cdot_accum_chk.sv
module cdot_accum_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [VLEN-1:0] in_src1,
  input logic [VLEN-1:0] in_acc,
  input logic            out_valid,
  input logic [VLEN-1:0] out_data
);
  // R10: reset empties the result flag on the next edge
  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: every accepted beat yields a result two clocks later
  a_r9_latency_fwd: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  // R9: no result without a beat two clocks earlier
  a_r9_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R11: a zero first source leaves the accumulator unchanged
  a_r11_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(in_src1, 2) == '0)) |-> (out_data == $past(in_acc, 2)));
endmodule

bind cdot_accum cdot_accum_chk #(.VLEN(VLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_src1  (in_src1),
  .in_acc   (in_acc),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/tb_cdot_accum.sv
module tb_cdot_accum;
  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic            in_size;
  logic [1:0]      in_rot;
  logic [VLEN-1:0] in_src1, in_src2, in_acc;
  logic            out_valid;
  logic [VLEN-1:0] out_data;

  cdot_accum #(.VLEN(VLEN)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size), .in_rot(in_rot),
    .in_src1(in_src1), .in_src2(in_src2), .in_acc(in_acc),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model of two-stage pipe: p1 = driven last negedge, p2 = two back
  logic            p1v = 0, p2v = 0;
  logic [VLEN-1:0] p1d, p2d;
  string           p1t = "", p2t = "";

  function automatic logic [VLEN-1:0] model(bit sz, logic [1:0] rot,
      logic [VLEN-1:0] x, logic [VLEN-1:0] y, logic [VLEN-1:0] c);
    logic [VLEN-1:0] r;
    longint xr, xi, yr, yi, t;
    r = c;
    if (!sz) begin
      for (int e = 0; e < VLEN/32; e++) begin
        logic [31:0] s;
        s = c[e*32 +: 32];
        for (int i = 0; i < 2; i++) begin
          xr = longint'($signed(x[(4*e+2*i)*8 +: 8]));
          xi = longint'($signed(x[(4*e+2*i+1)*8 +: 8]));
          yr = longint'($signed(y[(4*e+2*i)*8 +: 8]));
          yi = longint'($signed(y[(4*e+2*i+1)*8 +: 8]));
          case (rot)
            2'b00: t = xr*yr - xi*yi;
            2'b01: t = xr*yi + xi*yr;
            2'b10: t = xr*yr + xi*yi;
            default: t = xr*yi - xi*yr;
          endcase
          s = s + t[31:0];
        end
        r[e*32 +: 32] = s;
      end
    end else begin
      for (int e = 0; e < VLEN/64; e++) begin
        logic [63:0] s;
        s = c[e*64 +: 64];
        for (int i = 0; i < 2; i++) begin
          xr = longint'($signed(x[(4*e+2*i)*16 +: 16]));
          xi = longint'($signed(x[(4*e+2*i+1)*16 +: 16]));
          yr = longint'($signed(y[(4*e+2*i)*16 +: 16]));
          yi = longint'($signed(y[(4*e+2*i+1)*16 +: 16]));
          case (rot)
            2'b00: t = xr*yr - xi*yi;
            2'b01: t = xr*yi + xi*yr;
            2'b10: t = xr*yr + xi*yi;
            default: t = xr*yi - xi*yr;
          endcase
          s = s + t;
        end
        r[e*64 +: 64] = s;
      end
    end
    return r;
  endfunction

  function automatic string rtag(bit sz, logic [1:0] rot);
    string a;
    a = sz ? "R2" : "R1";
    case (rot)
      2'b00: return {a, "/R4"};
      2'b01: return {a, "/R5"};
      2'b10: return {a, "/R6"};
      default: return {a, "/R7"};
    endcase
  endfunction

  // one clock: check outputs, then drive the next inputs
  task automatic step(bit r, bit v, bit sz, logic [1:0] rot,
                      logic [VLEN-1:0] x, logic [VLEN-1:0] y, logic [VLEN-1:0] c, string tag);
    @(negedge clk);
    total++;
    if (out_valid !== p2v) begin
      bad++;
      $display("FAIL R9 out_valid actual=%b expected=%b (%s)", out_valid, p2v, p2t);
    end
    if (p2v) begin
      total++;
      if (out_data !== p2d) begin
        bad++;
        $display("FAIL %s out_data actual=%h expected=%h", p2t, out_data, p2d);
      end
    end
    p2v = p1v; p2d = p1d; p2t = p1t;
    rst = r; in_valid = v; in_size = sz; in_rot = rot;
    in_src1 = x; in_src2 = y; in_acc = c;
    p1v = v; p1d = model(sz, rot, x, y, c); p1t = tag;
    if (r) begin
      p1v = 0; p2v = 0;
    end
  endtask

  task automatic beat(bit sz, logic [1:0] rot, logic [VLEN-1:0] x,
                      logic [VLEN-1:0] y, logic [VLEN-1:0] c, string tag);
    step(0, 1, sz, rot, x, y, c, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 2'b00, '0, '0, '0, "R9");
  endtask

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 0; in_size = 0; in_rot = 0;
    in_src1 = '0; in_src2 = '0; in_acc = '0;
    repeat (3) step(1, 0, 0, 2'b00, '0, '0, '0, "R10");
    // reset state
    idle(); idle(); idle();

    // R8: most negative values in both formats, every rotation
    for (int k = 0; k < 4; k++) begin
      beat(0, 2'(k), {16{8'h80}}, {16{8'h80}}, '0, {"R8 ", rtag(0, 2'(k))});
      beat(1, 2'(k), {8{16'h8000}}, {8{16'h8000}}, '0, {"R8 ", rtag(1, 2'(k))});
    end
    // R8: accumulators at the positive wrap edge
    beat(0, 2'b10, {16{8'h7F}}, {16{8'h7F}}, {4{32'h7FFF_FFFF}}, "R8 wrap32");
    beat(1, 2'b10, {8{16'h7FFF}}, {8{16'h7FFF}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, "R8 wrap64");
    beat(0, 2'b00, {16{8'h01}}, {16{8'h7F}}, {4{32'hFFFF_FFFF}}, "R8 wrap32n");
    // R3: only the upper complex pair of each lane nonzero
    beat(0, 2'b01, {4{32'h0305_0000}}, {4{32'h0207_0000}}, {4{32'd10}}, "R3 pair1");
    beat(1, 2'b11, {2{64'h0003_0005_0000_0000}}, {2{64'h0002_0007_0000_0000}}, '0, "R3 pair1w");
    // R11: zero first source passes the accumulator
    beat(0, 2'b00, '0, rnd(), rnd(), "R11 narrow");
    beat(1, 2'b11, '0, rnd(), rnd(), "R11 wide");
    idle(); idle(); idle();

    // R10: reset with beats in flight
    beat(0, 2'b00, rnd(), rnd(), rnd(), "R10 pre");
    beat(1, 2'b01, rnd(), rnd(), rnd(), "R10 pre");
    step(1, 0, 0, 2'b00, '0, '0, '0, "R10");
    idle(); idle(); idle();

    // random mixed stream with back-to-back beats of differing format/rotation
    for (int n = 0; n < 600; n++) begin
      bit sz;
      logic [1:0] rot;
      sz  = 1'($urandom);
      rot = 2'($urandom);
      if (($urandom % 4) != 0)
        beat(sz, rot, rnd(), rnd(), rnd(), rtag(sz, rot));
      else
        idle();
    end
    idle(); idle(); idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule